// File: doc/BRIEF.md
# I2C General Call Command Decoder

This block sits on the target side of an I2C bus, behind a bit-level front end that reports START and STOP conditions and hands over each received data bit with a one-cycle strobe taken at the SCL rising edge. It watches the first byte after every START. If that byte is the all-zero general call address with a write direction bit, it drives the acknowledge during the ninth bit. It then decodes the following byte as a command.

Two commands are recognised. The first captures the external address-select pins. The second captures the pins and also pulses a soft reset toward the register file. Any other command byte draws no acknowledge and no strobe.

Captured pin values are held as pending. They become the visible address selection only when the transaction ends, either with STOP or with a repeated START. As a result, an address change never takes effect in the middle of a transfer.

Top module: `i2c_gcall_dec`

## Requirements
- R1: An address byte of 0x00 (seven zero address bits followed by R/W = 0, received MSB first) is acknowledged: `ack_o` is high from the cycle after its eighth bit strobe through the cycle of its ninth bit strobe.
- R2: Any other address byte, including 0x01 (general call with R/W = 1), is not acknowledged, and the rest of that transaction produces no acknowledge and no strobe.
- R3: After an acknowledged general call address, a command byte of 0x04 is acknowledged. `latch_addr_o` then pulses in the cycle after the command's ninth bit strobe, and `reg_rst_o` stays low.
- R4: A command byte of 0x06 is acknowledged, and `latch_addr_o` and `reg_rst_o` pulse together in the cycle after its ninth bit strobe.
- R5: Any command byte value other than 0x04 and 0x06 is not acknowledged and produces no strobe.
- R6: Each strobe is exactly one clock cycle wide, and `reg_rst_o` is never high without `latch_addr_o`.
- R7: Bytes that follow the command byte in the same transaction are not acknowledged.
- R8: `addr_pins_i` is sampled in the cycle `latch_addr_o` is high. `addr_sel_o` takes that value only at the next START or STOP, and keeps its previous value until then. When START or STOP falls in the latch cycle itself, the value being captured is the one applied.
- R9: START or STOP aborts any partly received byte. START restarts address decoding. After STOP, bits are ignored until the next START. `addr_sel_o` resets to zero.

Ports: (see table)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (one-cycle pulse) |
| stop_i | input | 1 | STOP seen (one-cycle pulse) |
| bit_stb_i | input | 1 | Received bit valid (one pulse per SCL rising edge, ninth bit included) |
| bit_i | input | 1 | Received SDA bit value |
| addr_pins_i | input | AW | External address-select pin states |
| ack_o | output | 1 | Drive SDA low for acknowledge |
| latch_addr_o | output | 1 | Address pin capture strobe |
| reg_rst_o | output | 1 | Register file soft-reset strobe |
| addr_sel_o | output | AW | Committed address selection |

## Verification
The pin capture from a latch strobe and the commit of pending pins at the end of a transaction can fall in the same cycle. The bench provokes this by driving STOP in exactly the cycle `latch_addr_o` is high. It then judges that `addr_sel_o` shows the pins sampled in that cycle, not the stale pending value. The reset strobe coincides with the latch strobe by design. Random transactions with 0x06 commands check that the two strobes are seen in the same sampled cycle, and that neither lingers into the next cycle.

// File: rtl/gc_pkg.sv
package gc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_LATCH    = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_LATCH_RST = 8'h06;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_CMD  = 2'd2,
    ST_SKIP = 2'd3
  } gc_state_e;
endpackage

// File: rtl/gc_shifter.sv
module gc_shifter #(
  parameter int unsigned BITS = 8,
  localparam int unsigned CW = $clog2(BITS + 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            bit_stb_i,
  input  logic            bit_i,
  output logic [BITS-1:0] byte_o,
  output logic            full_o,
  output logic            ninth_o
);
  logic [CW-1:0]   cnt_q;
  logic [BITS-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (bit_stb_i) begin
      if (cnt_q == CW'(BITS)) begin
        cnt_q <= '0;
      end else begin
        sh_q  <= {sh_q[BITS-2:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign full_o  = (cnt_q == CW'(BITS));
  assign ninth_o = full_o && bit_stb_i && !clear_i;
  assign byte_o  = sh_q;
endmodule

// File: rtl/gc_ctrl.sv
module gc_ctrl
  import gc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              full_i,
  input  logic              ninth_i,
  output logic              ack_o,
  output logic              latch_o,
  output logic              rst_o
);
  gc_state_e st_q, st_d;
  logic addr_hit, cmd_latch, cmd_rst, cmd_known;
  logic latch_q, rst_q;

  assign addr_hit  = (byte_i == GC_ADDR_BYTE);
  assign cmd_latch = (byte_i == CMD_LATCH);
  assign cmd_rst   = (byte_i == CMD_LATCH_RST);
  assign cmd_known = cmd_latch || cmd_rst;

  always_comb begin
    st_d = st_q;
    if (start_i) begin
      st_d = ST_ADDR;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else if (ninth_i) begin
      unique case (st_q)
        ST_ADDR: st_d = addr_hit ? ST_CMD : ST_SKIP;
        ST_CMD:  st_d = ST_SKIP;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      latch_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      latch_q <= ninth_i && !start_i && !stop_i && (st_q == ST_CMD) && cmd_known;
      rst_q   <= ninth_i && !start_i && !stop_i && (st_q == ST_CMD) && cmd_rst;
    end
  end

  // ack window: from byte complete through the ninth strobe
  assign ack_o = full_i && (((st_q == ST_ADDR) && addr_hit) ||
                            ((st_q == ST_CMD) && cmd_known));
  assign latch_o = latch_q;
  assign rst_o   = rst_q;
endmodule

// File: rtl/gc_addr_hold.sv
module gc_addr_hold #(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          commit_i,
  input  logic [AW-1:0] pins_i,
  output logic [AW-1:0] sel_o
);
  logic [AW-1:0] pend_q, sel_q;
  logic          pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      sel_q      <= '0;
    end else begin
      if (commit_i) begin
        // same-cycle capture wins over stale pending value
        if (capture_i)       sel_q <= pins_i;
        else if (pend_vld_q) sel_q <= pend_q;
        pend_vld_q <= 1'b0;
      end else if (capture_i) begin
        pend_q     <= pins_i;
        pend_vld_q <= 1'b1;
      end
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/i2c_gcall_dec.sv
module i2c_gcall_dec
  import gc_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          bit_stb_i,
  input  logic          bit_i,
  input  logic [AW-1:0] addr_pins_i,
  output logic          ack_o,
  output logic          latch_addr_o,
  output logic          reg_rst_o,
  output logic [AW-1:0] addr_sel_o
);
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_full, rx_ninth, bus_cond;

  assign bus_cond = start_i || stop_i;

  gc_shifter #(.BITS(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (bus_cond),
    .bit_stb_i (bit_stb_i),
    .bit_i     (bit_i),
    .byte_o    (rx_byte),
    .full_o    (rx_full),
    .ninth_o   (rx_ninth)
  );

  gc_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .byte_i  (rx_byte),
    .full_i  (rx_full),
    .ninth_i (rx_ninth),
    .ack_o   (ack_o),
    .latch_o (latch_addr_o),
    .rst_o   (reg_rst_o)
  );

  gc_addr_hold #(.AW(AW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (latch_addr_o),
    .commit_i  (bus_cond),
    .pins_i    (addr_pins_i),
    .sel_o     (addr_sel_o)
  );
endmodule

// File: rtl/gc_chk.sv
module gc_chk #(
  parameter int unsigned AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic          bit_stb_i,
  input logic          ack_o,
  input logic          latch_addr_o,
  input logic          reg_rst_o,
  input logic [AW-1:0] addr_sel_o
);
  AST_RST_WITH_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_o |-> latch_addr_o); // R6
  AST_LATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_addr_o |=> !latch_addr_o); // R6
  AST_STROBE_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_addr_o) |-> $past(bit_stb_i)); // R3
  AST_ACK_AFTER_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(bit_stb_i)); // R1
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !stop_i |=> $stable(addr_sel_o)); // R8
  AST_NO_ACK_AFTER_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> !ack_o); // R9
endmodule

bind i2c_gcall_dec gc_chk #(.AW(AW)) u_gc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .bit_stb_i    (bit_stb_i),
  .ack_o        (ack_o),
  .latch_addr_o (latch_addr_o),
  .reg_rst_o    (reg_rst_o),
  .addr_sel_o   (addr_sel_o)
);

// File: tb/i2c_gcall_dec_tb.sv
module i2c_gcall_dec_tb;
  localparam int AW = 3;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, stop_i = 0, bit_stb_i = 0, bit_i = 0;
  logic [AW-1:0] addr_pins_i = '0;
  logic ack_o, latch_addr_o, reg_rst_o;
  logic [AW-1:0] addr_sel_o;
  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] exp_sel = '0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_gcall_dec #(.AW(AW)) u_dut (.clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .bit_stb_i(bit_stb_i), .bit_i(bit_i), .addr_pins_i(addr_pins_i), .ack_o(ack_o),
    .latch_addr_o(latch_addr_o), .reg_rst_o(reg_rst_o), .addr_sel_o(addr_sel_o));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit f_ack_cmd(logic [7:0] a, logic [7:0] c);
    return a == 8'h00 && (c == 8'h04 || c == 8'h06);
  endfunction

  task automatic cond(bit is_start);
    @(negedge clk); if (is_start) start_i = 1; else stop_i = 1;
    @(negedge clk); start_i = 0; stop_i = 0;
  endtask

  task automatic bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); bit_i = b[i]; bit_stb_i = 1;
      @(negedge clk); bit_stb_i = 0;
    end
  endtask

  // full byte plus ninth clock; returns ack and strobes seen
  task automatic xbyte(logic [7:0] b, bit stop_in_latch, output bit ack, output bit lat,
                       output bit rr, output bit lat2);
    bits(b, 8);
    ack = ack_o;
    bit_stb_i = 1;
    @(negedge clk); bit_stb_i = 0;
    lat = latch_addr_o; rr = reg_rst_o;
    if (stop_in_latch) stop_i = 1;
    @(negedge clk); stop_i = 0;
    lat2 = latch_addr_o | reg_rst_o;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit a, l, r, l2;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R9 reset sel", addr_sel_o, 0);
    chk("R9 reset ack", ack_o, 0);
    chk("R6 reset strobes", latch_addr_o | reg_rst_o, 0);
    rst_ni = 1;

    // directed: latch-only command
    addr_pins_i = 3'b101;
    cond(1);
    xbyte(8'h00, 0, a, l, r, l2); chk("R1 gc addr ack", a, 1); chk("R1 no strobe on addr", l, 0);
    xbyte(8'h04, 0, a, l, r, l2); chk("R3 cmd ack", a, 1); chk("R3 latch", l, 1);
    chk("R3 no reset", r, 0); chk("R6 width", l2, 0);
    addr_pins_i = 3'b010;
    chk("R8 held until stop", addr_sel_o, 0);
    xbyte(8'h00, 0, a, l, r, l2); chk("R7 trailing byte no ack", a, 0);
    cond(0);
    chk("R8 commit at stop", addr_sel_o, 3'b101); exp_sel = 3'b101;

    // general call read: not acknowledged
    cond(1);
    xbyte(8'h01, 0, a, l, r, l2); chk("R2 read gc no ack", a, 0);
    xbyte(8'h06, 0, a, l, r, l2); chk("R2 no strobe after nack", l | r | a, 0);
    cond(0);

    // bits after STOP ignored
    xbyte(8'h00, 0, a, l, r, l2); chk("R9 idle no ack", a, 0);

    // STOP mid command byte aborts
    cond(1);
    xbyte(8'h00, 0, a, l, r, l2);
    bits(8'h06, 4); cond(0);
    bits(8'h06, 4);
    @(negedge clk); chk("R9 abort no ack", ack_o, 0);
    chk("R9 abort keeps sel", addr_sel_o, exp_sel);

    // repeated START mid address, then full reset command, STOP in latch cycle
    cond(1); bits(8'h00, 3); cond(1);
    addr_pins_i = 3'b011;
    xbyte(8'h00, 0, a, l, r, l2); chk("R9 restart ack", a, 1);
    xbyte(8'h06, 1, a, l, r, l2); chk("R4 latch", l, 1); chk("R4 reset", r, 1);
    chk("R8 same-cycle commit", addr_sel_o, 3'b011); exp_sel = 3'b011;

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [7:0] ab, cb;
      logic [AW-1:0] pins;
      bit ak;
      int sel = $urandom_range(0, 3);
      ab = (sel == 0) ? 8'h01 : (sel == 3) ? 8'($urandom) : 8'h00;
      sel = $urandom_range(0, 3);
      cb = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h06 : 8'($urandom);
      pins = AW'($urandom);
      addr_pins_i = pins;
      cond(1);
      xbyte(ab, 0, a, l, r, l2); chk("R1 R2 addr ack", a, ab == 8'h00);
      xbyte(cb, 0, a, l, r, l2);
      ak = f_ack_cmd(ab, cb);
      chk("R5 cmd ack", a, ak);
      chk("R3 latch", l, ak);
      chk("R4 reset", r, ak && cb == 8'h06);
      chk("R6 width", l2, 0);
      addr_pins_i = ~pins;
      chk("R8 hold", addr_sel_o, exp_sel);
      if (ak) exp_sel = pins;
      cond($urandom_range(0, 1));
      chk("R8 commit", addr_sel_o, exp_sel);
    end
    cond(0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule